// File: doc/BRIEF.md
# Firmware Image Ping-Pong Loader

This block is a host-side sequencer that pushes a firmware image to a peer controller. The handover goes through a byte-wide staging window and a mailbox of three 32-bit words: a status word, a flag owned by the peer and a flag owned by the host. A load begins with a prepare command. The sequencer then zeroes the mailbox, places a fixed-size header in the staging window and issues a go command. After that it feeds the image body in chunks. Each time the peer asks for data it names a low or a high phase in its status word. The host answers by refilling the staging window and flipping its own flag, so the flag alternates 1, 0, 1, 0 across the chunks.

Image bytes come in on a valid/ready byte stream. Each accepted byte is written into the window in the same cycle. Command words leave on a strobe with a 16-bit word. Mailbox writes leave on a strobe with a word select and a value. The peer's status and flag words are read as level inputs. A load ends in a sticky done or fail state, and fail comes with a code. Every wait on the peer is limited by a cycle timeout, and the header size, chunk size, image limit and timeout are all parameters.

Top module: `fw_ping_pong_loader`

## Requirements
- R1: After reset, and until a start is seen, busy, done and fail are low, the fail code is 0, and no window, command or mailbox strobe is raised.
- R2: A start whose image length is below HDR_BYTES or above MAX_IMG_BYTES goes to fail with code 4 and issues no command or mailbox write.
- R3: A valid start issues command 0x10FE. Over the next three cycles it writes zero to mailbox select 0 (status), then select 1 (peer flag), then select 2 (host flag).
- R4: Next, HDR_BYTES header bytes go to window addresses 0 upward. Then command 0x20FE is issued. These are the only two command words the block ever emits.
- R5: A byte is taken from the source only when valid and ready are both high. In that same cycle it is written to the window. Its address is its position within the current segment, and that position restarts at 0 for every header or chunk.
- R6: After go, the block waits for a peer flag of 1 and a status of 0x54784C4F. It then copies min(CHUNK_BYTES, bytes left) bytes, writes 1 to the host flag, and waits for the peer flag to differ from 1.
- R7: It then waits for status 0x54784849. It copies the next min(CHUNK_BYTES, bytes left) bytes, writes 0 to the host flag, and waits for a nonzero peer flag.
- R8: If the status is 0x54784C4F after a high-phase handshake, the block runs another low phase. Once the image is used up, a chunk carries zero bytes and only the flag toggles.
- R9: A status of 0x4241444E ends the load in fail with code 2. This applies while waiting for a phase request and after either flag handshake.
- R10: If the status is 0x444F4E45 after a high-phase handshake, the load ends in done. Any other status there that is not a phase request or bad media ends it in fail with code 3.
- R11: Any wait on the mailbox that lasts TIMEOUT_CYC cycles ends the load in fail with code 1.
- R12: Done and fail are never high together. Both hold until the next start, and that start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load (accepted when idle, done or failed) |
| img_len_i | input | LEN_W | Image length in bytes, header included |
| src_valid_i | input | 1 | Source byte valid |
| src_data_i | input | 8 | Source byte |
| src_ready_o | output | 1 | Loader accepts a source byte |
| win_we_o | output | 1 | Staging window write strobe |
| win_addr_o | output | WIN_AW | Staging window byte address |
| win_data_o | output | 8 | Staging window write data |
| cmd_we_o | output | 1 | Command strobe |
| cmd_o | output | 16 | Command word |
| mbx_we_o | output | 1 | Mailbox write strobe |
| mbx_sel_o | output | 2 | Mailbox word: 0 status, 1 peer flag, 2 host flag |
| mbx_wdata_o | output | 32 | Mailbox write value |
| mbx_status_i | input | 32 | Mailbox status word as currently stored |
| mbx_peer_flag_i | input | 32 | Mailbox peer flag as currently stored |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load completed successfully (sticky) |
| fail_o | output | 1 | Load aborted (sticky) |
| fail_code_o | output | 3 | 0 none, 1 timeout, 2 bad media, 3 bad final status, 4 bad length |

## Verification
A small peer model replays a scripted series of status and flag replies. The same loader runs against several scripts. One is a single low/high pair with a short high chunk. Another makes a second low request, which tells the loop-back path and the zero-byte chunk apart from a plain two-phase load. Others are bad media after the first chunk, an unknown final word, and a peer that never answers, which separate the three abort codes. Length values just outside both limits check the rejection, and a source that stalls every third cycle shows that bytes and window addresses stay aligned under backpressure.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  localparam logic [15:0] CMD_PREP = 16'h10FE;
  localparam logic [15:0] CMD_GO   = 16'h20FE;

  localparam logic [31:0] ST_LOW   = 32'h54784C4F;
  localparam logic [31:0] ST_HIGH  = 32'h54784849;
  localparam logic [31:0] ST_BAD   = 32'h4241444E;
  localparam logic [31:0] ST_OK    = 32'h444F4E45;

  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_TIMEOUT = 3'd1,
    FC_MEDIA   = 3'd2,
    FC_FINAL   = 3'd3,
    FC_LEN     = 3'd4
  } fail_e;

  typedef enum logic [1:0] {
    MB_STATUS = 2'd0,
    MB_PEER   = 2'd1,
    MB_HOST   = 2'd2
  } mbx_sel_e;

  typedef enum logic [4:0] {
    S_IDLE, S_PREP, S_CLR_ST, S_CLR_PF, S_CLR_HF, S_HDR, S_GO,
    S_W_PEER, S_W_LOW, S_LOW, S_HF1, S_W_LEAVE, S_W_HIGH,
    S_HIGH, S_HF0, S_W_NZ, S_DONE, S_FAIL
  } state_e;
endpackage

// File: rtl/fwl_wait_timer.sv
module fwl_wait_timer #(
  parameter int LIMIT = 1000,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic expired_o
);
  logic [W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (restart_i)     cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fwl_chunk_copier.sv
module fwl_chunk_copier #(
  parameter int AW = 3,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          src_valid_i,
  input  logic [7:0]    src_data_i,
  output logic          src_ready_o,
  output logic          win_we_o,
  output logic [AW-1:0] win_addr_o,
  output logic [7:0]    win_data_o,
  output logic          done_o
);
  logic          active_q, zero_q;
  logic [CW-1:0] idx_q, last_q;
  logic          fire, last;

  assign fire        = active_q && src_valid_i;
  assign last        = (idx_q == last_q);
  assign src_ready_o = active_q;
  assign win_we_o    = fire;
  assign win_addr_o  = idx_q[AW-1:0];
  assign win_data_o  = src_data_i;
  // empty chunk finishes one cycle after start
  assign done_o      = (fire && last) || zero_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      zero_q   <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
    end else if (start_i) begin
      active_q <= (count_i != '0);
      zero_q   <= (count_i == '0);
      idx_q    <= '0;
      last_q   <= count_i - 1'b1;
    end else begin
      zero_q <= 1'b0;
      if (fire) begin
        idx_q <= idx_q + 1'b1;
        if (last) active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fw_ping_pong_loader.sv
module fw_ping_pong_loader #(
  parameter int HDR_BYTES     = 2048,
  parameter int CHUNK_BYTES   = 131072,
  parameter int MAX_IMG_BYTES = 262144,
  parameter int TIMEOUT_CYC   = 1000000,
  localparam int SEG_MAX = (HDR_BYTES > CHUNK_BYTES) ? HDR_BYTES : CHUNK_BYTES,
  localparam int WIN_AW  = $clog2(SEG_MAX),
  localparam int CNT_W   = $clog2(SEG_MAX + 1),
  localparam int LEN_W   = $clog2(MAX_IMG_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  img_len_i,
  input  logic              src_valid_i,
  input  logic [7:0]        src_data_i,
  output logic              src_ready_o,
  output logic              win_we_o,
  output logic [WIN_AW-1:0] win_addr_o,
  output logic [7:0]        win_data_o,
  output logic              cmd_we_o,
  output logic [15:0]       cmd_o,
  output logic              mbx_we_o,
  output logic [1:0]        mbx_sel_o,
  output logic [31:0]       mbx_wdata_o,
  input  logic [31:0]       mbx_status_i,
  input  logic [31:0]       mbx_peer_flag_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [2:0]        fail_code_o
);
  import fwl_pkg::*;

  state_e           state_q, state_d;
  fail_e            code_q, code_d;
  logic [LEN_W-1:0] rem_q;
  logic [CNT_W-1:0] cp_count;
  logic             cp_start, cp_done, tmo, waiting, copying, len_bad;

  assign waiting = (state_q inside {S_W_PEER, S_W_LOW, S_W_LEAVE, S_W_HIGH, S_W_NZ});
  assign copying = (state_d inside {S_HDR, S_LOW, S_HIGH});
  assign cp_start = copying && (state_d != state_q);
  assign len_bad  = (img_len_i < LEN_W'(HDR_BYTES)) || (img_len_i > LEN_W'(MAX_IMG_BYTES));

  always_comb begin
    if (state_d == S_HDR)                         cp_count = CNT_W'(HDR_BYTES);
    else if (rem_q >= LEN_W'(CHUNK_BYTES))        cp_count = CNT_W'(CHUNK_BYTES);
    else                                          cp_count = CNT_W'(rem_q);
  end

  fwl_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (state_d != state_q),
    .run_i     (waiting),
    .expired_o (tmo)
  );

  fwl_chunk_copier #(.AW(WIN_AW), .CW(CNT_W)) u_copy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (cp_start),
    .count_i     (cp_count),
    .src_valid_i (src_valid_i),
    .src_data_i  (src_data_i),
    .src_ready_o (src_ready_o),
    .win_we_o    (win_we_o),
    .win_addr_o  (win_addr_o),
    .win_data_o  (win_data_o),
    .done_o      (cp_done)
  );

  always_comb begin
    state_d     = state_q;
    code_d      = code_q;
    cmd_we_o    = 1'b0;
    cmd_o       = CMD_PREP;
    mbx_we_o    = 1'b0;
    mbx_sel_o   = MB_STATUS;
    mbx_wdata_o = '0;
    unique case (state_q)
      S_IDLE, S_DONE, S_FAIL: if (start_i) begin
        if (len_bad) begin
          state_d = S_FAIL;
          code_d  = FC_LEN;
        end else begin
          state_d = S_PREP;
          code_d  = FC_NONE;
        end
      end
      S_PREP: begin
        cmd_we_o = 1'b1;
        state_d  = S_CLR_ST;
      end
      S_CLR_ST: begin
        mbx_we_o = 1'b1;
        state_d  = S_CLR_PF;
      end
      S_CLR_PF: begin
        mbx_we_o  = 1'b1;
        mbx_sel_o = MB_PEER;
        state_d   = S_CLR_HF;
      end
      S_CLR_HF: begin
        mbx_we_o  = 1'b1;
        mbx_sel_o = MB_HOST;
        state_d   = S_HDR;
      end
      S_HDR: if (cp_done) state_d = S_GO;
      S_GO: begin
        cmd_we_o = 1'b1;
        cmd_o    = CMD_GO;
        state_d  = S_W_PEER;
      end
      S_W_PEER: begin
        if (mbx_peer_flag_i == 32'd1) state_d = S_W_LOW;
        else if (tmo) begin state_d = S_FAIL; code_d = FC_TIMEOUT; end
      end
      S_W_LOW: begin
        if (mbx_status_i == ST_LOW) state_d = S_LOW;
        else if (mbx_status_i == ST_BAD) begin state_d = S_FAIL; code_d = FC_MEDIA; end
        else if (tmo) begin state_d = S_FAIL; code_d = FC_TIMEOUT; end
      end
      S_LOW: if (cp_done) state_d = S_HF1;
      S_HF1: begin
        mbx_we_o    = 1'b1;
        mbx_sel_o   = MB_HOST;
        mbx_wdata_o = 32'd1;
        state_d     = S_W_LEAVE;
      end
      S_W_LEAVE: begin
        if (mbx_peer_flag_i != 32'd1) begin
          if (mbx_status_i == ST_BAD) begin state_d = S_FAIL; code_d = FC_MEDIA; end
          else state_d = S_W_HIGH;
        end else if (tmo) begin state_d = S_FAIL; code_d = FC_TIMEOUT; end
      end
      S_W_HIGH: begin
        if (mbx_status_i == ST_HIGH) state_d = S_HIGH;
        else if (mbx_status_i == ST_BAD) begin state_d = S_FAIL; code_d = FC_MEDIA; end
        else if (tmo) begin state_d = S_FAIL; code_d = FC_TIMEOUT; end
      end
      S_HIGH: if (cp_done) state_d = S_HF0;
      S_HF0: begin
        mbx_we_o  = 1'b1;
        mbx_sel_o = MB_HOST;
        state_d   = S_W_NZ;
      end
      S_W_NZ: begin
        if (mbx_peer_flag_i != 32'd0) begin
          if (mbx_status_i == ST_BAD)      begin state_d = S_FAIL; code_d = FC_MEDIA; end
          else if (mbx_status_i == ST_LOW) state_d = S_LOW;
          else if (mbx_status_i == ST_OK)  state_d = S_DONE;
          else                             begin state_d = S_FAIL; code_d = FC_FINAL; end
        end else if (tmo) begin state_d = S_FAIL; code_d = FC_TIMEOUT; end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      code_q  <= FC_NONE;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      if (state_d == S_PREP && state_q != S_PREP) rem_q <= img_len_i;
      else if (win_we_o)                           rem_q <= rem_q - 1'b1;
    end
  end

  assign busy_o      = !(state_q inside {S_IDLE, S_DONE, S_FAIL});
  assign done_o      = (state_q == S_DONE);
  assign fail_o      = (state_q == S_FAIL);
  assign fail_code_o = code_q;
endmodule

// File: rtl/fwl_loader_chk.sv
module fwl_loader_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        src_valid_i,
  input logic        src_ready_o,
  input logic        win_we_o,
  input logic        cmd_we_o,
  input logic [15:0] cmd_o,
  input logic        mbx_we_o,
  input logic [1:0]  mbx_sel_o,
  input logic [31:0] mbx_wdata_o,
  input logic        done_o,
  input logic        fail_o,
  input logic [2:0]  fail_code_o
);
  // R3
  prep_then_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_o && cmd_o == 16'h10FE) |=> (mbx_we_o && mbx_sel_o == 2'd0 && mbx_wdata_o == 32'd0));
  // R4
  cmd_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_o |-> (cmd_o == 16'h10FE || cmd_o == 16'h20FE));
  // R5
  win_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_we_o |-> (src_valid_i && src_ready_o));
  // R7
  host_flag_bin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbx_we_o && mbx_sel_o == 2'd2) |-> (mbx_wdata_o <= 32'd1));
  // R12
  done_fail_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
  // R12
  fail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> fail_o);
  // R12
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  // R2
  fail_has_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (fail_code_o != 3'd0));
endmodule

bind fw_ping_pong_loader fwl_loader_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .src_valid_i (src_valid_i),
  .src_ready_o (src_ready_o),
  .win_we_o    (win_we_o),
  .cmd_we_o    (cmd_we_o),
  .cmd_o       (cmd_o),
  .mbx_we_o    (mbx_we_o),
  .mbx_sel_o   (mbx_sel_o),
  .mbx_wdata_o (mbx_wdata_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .fail_code_o (fail_code_o)
);

// File: tb/fw_ping_pong_loader_test.sv
module fw_ping_pong_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int HDR = 4, CHUNK = 8, MAXL = 24, TMO = 40;
  localparam int LW = $clog2(MAXL + 1);
  localparam int AW = $clog2(CHUNK);
  localparam logic [31:0] ST_LOW = 32'h54784C4F, ST_HIGH = 32'h54784849;
  localparam logic [31:0] ST_BAD = 32'h4241444E, ST_OK = 32'h444F4E45;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tb_clr = 1'b0;
  logic [LW-1:0] img_len = '0;
  logic src_valid, src_ready, win_we, cmd_we, mbx_we, busy, done, fail;
  logic [7:0] src_data, win_data;
  logic [AW-1:0] win_addr;
  logic [15:0] cmd;
  logic [1:0] mbx_sel;
  logic [31:0] mbx_wdata, mbx_st, mbx_pf;
  logic [2:0] fail_code;

  int checks = 0, fails = 0;
  int src_pos, wpos, seg_pos, err, ev_n, hf_n, pend, scr_i, vcnt;
  int scr_n = 0;
  logic [31:0] scr_st [0:7];
  logic [31:0] scr_pf [0:7];
  int ev_kind [0:31];
  int ev_sel  [0:31];
  logic [31:0] ev_val [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] byte_of(int p);
    return 8'((p * 7 + 3) & 255);
  endfunction

  assign src_valid = (vcnt % 3) != 2;
  assign src_data  = byte_of(src_pos);

  fw_ping_pong_loader #(.HDR_BYTES(HDR), .CHUNK_BYTES(CHUNK),
                        .MAX_IMG_BYTES(MAXL), .TIMEOUT_CYC(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .img_len_i(img_len),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .win_we_o(win_we), .win_addr_o(win_addr), .win_data_o(win_data),
    .cmd_we_o(cmd_we), .cmd_o(cmd), .mbx_we_o(mbx_we), .mbx_sel_o(mbx_sel),
    .mbx_wdata_o(mbx_wdata), .mbx_status_i(mbx_st), .mbx_peer_flag_i(mbx_pf),
    .busy_o(busy), .done_o(done), .fail_o(fail), .fail_code_o(fail_code));

  // peer, mailbox storage, source and window monitor
  always @(posedge clk) begin
    vcnt <= vcnt + 1;
    if (tb_clr) begin
      pend <= 0; scr_i <= 0; wpos <= 0; seg_pos <= 0; err <= 0;
      ev_n <= 0; hf_n <= 0; mbx_st <= '0; mbx_pf <= '0; src_pos <= 0;
    end else begin
      if (src_valid && src_ready) src_pos <= src_pos + 1;
      if (win_we) begin
        if (win_data != byte_of(wpos) || int'(win_addr) != seg_pos) err <= err + 1;
        wpos <= wpos + 1;
        seg_pos <= seg_pos + 1;
      end
      if (cmd_we || mbx_we) begin
        seg_pos <= 0;
        if (ev_n < 32) begin
          ev_kind[ev_n] <= cmd_we ? 0 : 1;
          ev_sel[ev_n]  <= int'(mbx_sel);
          ev_val[ev_n]  <= cmd_we ? {16'h0, cmd} : mbx_wdata;
          ev_n <= ev_n + 1;
        end
      end
      if (mbx_we && mbx_sel == 2'd0) mbx_st <= mbx_wdata;
      if (mbx_we && mbx_sel == 2'd1) mbx_pf <= mbx_wdata;
      if ((cmd_we && cmd == 16'h20FE) || (mbx_we && mbx_sel == 2'd2 && ev_n > 3)) begin
        pend <= 3;
        if (mbx_we) hf_n <= hf_n + 1;
      end else if (pend != 0) begin
        pend <= pend - 1;
        if (pend == 1 && scr_i < scr_n) begin
          mbx_st <= scr_st[scr_i];
          mbx_pf <= scr_pf[scr_i];
          scr_i  <= scr_i + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_load(input int len, output int cycles);
    @(negedge clk); tb_clr = 1'b1;
    @(negedge clk); tb_clr = 1'b0;
    img_len = LW'(len); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cycles = 0;
    while (!done && !fail && cycles < 2000) begin
      @(negedge clk); cycles++;
    end
    if (cycles >= 2000) chk(0, "run_end", cycles, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fail, "R1 status idle", {busy, done, fail}, 0);
    chk(fail_code == 3'd0, "R1 code", fail_code, 0);
    chk(!win_we && !cmd_we && !mbx_we && !src_ready, "R1 strobes",
        {win_we, cmd_we, mbx_we, src_ready}, 0);
  endtask

  task automatic t_bad_len();
    int c;
    scr_n = 0;
    run_load(HDR - 1, c);
    chk(fail && fail_code == 3'd4, "R2 short len", fail_code, 4);
    chk(ev_n == 0, "R2 short no writes", ev_n, 0);
    run_load(MAXL + 1, c);
    chk(fail && fail_code == 3'd4, "R2 long len", fail_code, 4);
    chk(ev_n == 0 && wpos == 0, "R2 long no writes", ev_n, 0);
    repeat (5) @(negedge clk);
    chk(fail && !done, "R12 fail sticky", fail, 1);
  endtask

  task automatic t_normal();
    int c;
    scr_st[0] = ST_LOW;  scr_pf[0] = 1;
    scr_st[1] = ST_HIGH; scr_pf[1] = 0;
    scr_st[2] = ST_OK;   scr_pf[2] = 1;
    scr_n = 3;
    run_load(17, c);
    chk(done && !fail, "R10 done", {done, fail}, 2);
    chk(fail_code == 3'd0, "R12 code cleared by start", fail_code, 0);
    chk(ev_kind[0] == 0 && ev_val[0] == 32'h10FE, "R3 prepare first", ev_val[0], 32'h10FE);
    chk(ev_kind[1] == 1 && ev_sel[1] == 0 && ev_val[1] == 0, "R3 clear status", ev_sel[1], 0);
    chk(ev_kind[2] == 1 && ev_sel[2] == 1 && ev_val[2] == 0, "R3 clear peer flag", ev_sel[2], 1);
    chk(ev_kind[3] == 1 && ev_sel[3] == 2 && ev_val[3] == 0, "R3 clear host flag", ev_sel[3], 2);
    chk(ev_kind[4] == 0 && ev_val[4] == 32'h20FE, "R4 go after header", ev_val[4], 32'h20FE);
    chk(ev_sel[5] == 2 && ev_val[5] == 1, "R6 host flag 1", ev_val[5], 1);
    chk(ev_sel[6] == 2 && ev_val[6] == 0, "R7 host flag 0", ev_val[6], 0);
    chk(wpos == 17, "R7 byte total", wpos, 17);
    chk(err == 0, "R5 data and address", err, 0);
  endtask

  task automatic t_loop_back();
    int c;
    scr_st[0] = ST_LOW;  scr_pf[0] = 1;
    scr_st[1] = ST_HIGH; scr_pf[1] = 0;
    scr_st[2] = ST_LOW;  scr_pf[2] = 1;
    scr_st[3] = ST_HIGH; scr_pf[3] = 0;
    scr_st[4] = ST_OK;   scr_pf[4] = 1;
    scr_n = 5;
    run_load(23, c);
    chk(done, "R8 loop done", done, 1);
    chk(hf_n == 4, "R8 four flag toggles", hf_n, 4);
    chk(wpos == 23, "R8 zero byte last chunk", wpos, 23);
    chk(err == 0, "R5 loop data", err, 0);
  endtask

  task automatic t_bad_media();
    int c;
    scr_st[0] = ST_LOW; scr_pf[0] = 1;
    scr_st[1] = ST_BAD; scr_pf[1] = 0;
    scr_n = 2;
    run_load(17, c);
    chk(fail && fail_code == 3'd2, "R9 bad media", fail_code, 2);
    chk(wpos == 12, "R9 stopped after chunk", wpos, 12);
  endtask

  task automatic t_bad_final();
    int c;
    scr_st[0] = ST_LOW;  scr_pf[0] = 1;
    scr_st[1] = ST_HIGH; scr_pf[1] = 0;
    scr_st[2] = 32'h12345678; scr_pf[2] = 1;
    scr_n = 3;
    run_load(17, c);
    chk(fail && !done && fail_code == 3'd3, "R10 bad final", fail_code, 3);
  endtask

  task automatic t_timeout();
    int c;
    scr_n = 0;
    @(negedge clk); tb_clr = 1'b1;
    @(negedge clk); tb_clr = 1'b0;
    img_len = LW'(17); start = 1'b1;
    @(negedge clk); start = 1'b0;
    c = 0;
    while (!(cmd_we && cmd == 16'h20FE) && c < 200) begin @(negedge clk); c++; end
    c = 0;
    while (!fail && c < 500) begin @(negedge clk); c++; end
    chk(fail && fail_code == 3'd1, "R11 timeout code", fail_code, 1);
    chk(c >= TMO && c <= TMO + 2, "R11 timeout window", c, TMO + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    vcnt = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_bad_len();
    t_normal();
    t_loop_back();
    t_bad_media();
    t_bad_final();
    t_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule